// File: doc/BRIEF.md
# Memory Bank Boundary Decoder

This block turns a physical memory address into a chip-select for one of up to eight memory banks. Each bank owns an address window given by a lower bound and an upper bound, plus an enable bit. Banks need not share a size, and their windows need not be aligned to a power of two. Each window is therefore tested on its own. Comparisons use the upper address bits only, so the block works at a fixed granularity. With the default parameters that granularity is 1 MB, and 12 address bits take part in the comparison.

Initialization software loads the bounds and the enable mask through a small write port. The memory controller then presents one address per cycle with a valid strobe. One clock later the block returns three results: a one-hot select vector, the index of the selected bank, and a hit or miss flag. When two enabled windows overlap, the lower-numbered bank takes the access. An address that falls in no enabled window produces a miss and selects nothing.

Top module: `mem_bank_decoder`

## Requirements
- R1: After a synchronous active-low reset, all bounds and all enable bits are zero. Every access then misses and asserts no select.
- R2: A bank matches when start <= blk <= end, where blk is acc_addr_i[ADDR_W-1:GRAN_LSB]. Both bounds are inclusive.
- R3: A bank whose enable bit is 0 never asserts its select.
- R4: When several enabled banks match, only the lowest-numbered one is selected, so at most one bit of cs_o is set.
- R5: A valid access that matches no enabled bank raises miss_o, clears hit_o and leaves cs_o all zero.
- R6: When hit_o is 1, bank_idx_o holds the index of the single set bit of cs_o, and cs_o equals 1 shifted left by that index.
- R7: Results appear exactly one clock after acc_valid_i is sampled, flagged by out_valid_o. In a cycle that follows no access, out_valid_o, cs_o, hit_o and miss_o are all 0.
- R8: Write port encoding on cfg_kind_i is 0 = lower bound of bank cfg_bank_i, 1 = upper bound of bank cfg_bank_i, 2 = enable mask. For the enable mask, bit i of cfg_wdata_i enables bank i and cfg_bank_i is ignored. Code 3 changes nothing.
- R9: A bank whose lower bound is greater than its upper bound matches no address.
- R10: Address bits below GRAN_LSB have no effect on the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Write target: 0 lower bound, 1 upper bound, 2 enable mask, 3 none |
| cfg_bank_i | input | 3 | Bank addressed by a bound write |
| cfg_wdata_i | input | 12 | Bound value in granules, or the enable mask in the low 8 bits |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 32 | Physical access address |
| out_valid_o | output | 1 | A decode result is present |
| cs_o | output | 8 | One-hot bank select |
| bank_idx_o | output | 3 | Index of the selected bank |
| hit_o | output | 1 | Access fell in an enabled bank |
| miss_o | output | 1 | Access fell in no enabled bank |

## Verification
A corrupted bound or enable bit inside the block shows up at the ports on the first access to an address near that bank's window. The fault appears one clock after that access, as a wrong select, a wrong index, or a miss where a hit was due. To catch such faults, the bench sweeps every granule of the 12-bit compare space under several register images and compares each result with an arithmetic model. The images include overlapping windows, a single-granule window, an inverted window, a disabled bank and an all-zero reset image, so a stuck bound bit or a wrong priority order fails within that sweep. The cycle after each access is also checked, so a select that lingers past its cycle is seen at once.

// File: rtl/mbd_pkg.sv
// Package: shared types for the memory bank boundary decoder.
// Assumes the write-kind code values below are fixed by the requirements.
package mbd_pkg;
    typedef enum logic [1:0] {
        CFG_LOWER  = 2'd0,
        CFG_UPPER  = 2'd1,
        CFG_ENMASK = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/mbd_regs.sv
// Module: holds the per-bank lower/upper bounds and the enable mask.
// Assumes CMP_W >= NUM_BANKS so the enable mask fits in the write data.
module mbd_regs #(
    parameter int NUM_BANKS = 8,
    parameter int CMP_W     = 12,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we_i,
    input  mbd_pkg::cfg_kind_e                  kind_i,
    input  logic [BANK_W-1:0]                   bank_i,
    input  logic [CMP_W-1:0]                    wdata_i,
    output logic [NUM_BANKS-1:0][CMP_W-1:0]     lower_o,
    output logic [NUM_BANKS-1:0][CMP_W-1:0]     upper_o,
    output logic [NUM_BANKS-1:0]                en_o
);
    import mbd_pkg::*;

    // Load bounds and mask from the write port; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lower_o <= '0;
            upper_o <= '0;
            en_o    <= '0;
        end else if (we_i) begin
            case (kind_i)
                CFG_LOWER:  lower_o[bank_i] <= wdata_i;
                CFG_UPPER:  upper_o[bank_i] <= wdata_i;
                CFG_ENMASK: en_o            <= wdata_i[NUM_BANKS-1:0];
                default:    ;
            endcase
        end
    end

    // R8: the unused write code leaves every register unchanged.
    assert_none_kind_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && kind_i == CFG_NONE) |=> ($stable(lower_o) && $stable(upper_o) && $stable(en_o)));

    // R1: the cycle after reset, the enable mask is clear.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (en_o == '0));
endmodule

// File: rtl/mbd_window.sv
// Module: inclusive window test for one bank at granule resolution.
// Assumes both bounds are in granules; an inverted window never matches.
module mbd_window #(
    parameter int CMP_W = 12
) (
    input  logic [CMP_W-1:0] blk_i,
    input  logic [CMP_W-1:0] lower_i,
    input  logic [CMP_W-1:0] upper_i,
    input  logic             en_i,
    output logic             match_o
);
    // Match only when enabled and lower <= blk <= upper.
    always_comb begin
        match_o = en_i && (blk_i >= lower_i) && (blk_i <= upper_i);
    end
endmodule

// File: rtl/mbd_prio.sv
// Module: picks the lowest-numbered matching bank and encodes it.
// Assumes match bits arrive already gated by each bank's enable.
module mbd_prio #(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] match_i,
    output logic [NUM_BANKS-1:0] sel_o,
    output logic [BANK_W-1:0]    idx_o,
    output logic                 any_o
);
    // Scan from the top down so that the lowest match is written last.
    always_comb begin
        idx_o = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match_i[i]) idx_o = i[BANK_W-1:0];
        end
        any_o = |match_i;
        sel_o = any_o ? (NUM_BANKS'(1) << idx_o) : '0;
    end
endmodule

// File: rtl/mem_bank_decoder.sv
// Module: top of the bank boundary decoder. Holds the configuration
// registers, tests every bank window in parallel, resolves overlaps by
// lowest index, and registers the result one clock after the access.
// Assumes accesses arrive at most one per clock with acc_valid_i.
module mem_bank_decoder #(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LSB  = 20,
    localparam int CMP_W    = ADDR_W - GRAN_LSB,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_kind_i,
    input  logic [BANK_W-1:0]    cfg_bank_i,
    input  logic [CMP_W-1:0]     cfg_wdata_i,
    input  logic                 acc_valid_i,
    input  logic [ADDR_W-1:0]    acc_addr_i,
    output logic                 out_valid_o,
    output logic [NUM_BANKS-1:0] cs_o,
    output logic [BANK_W-1:0]    bank_idx_o,
    output logic                 hit_o,
    output logic                 miss_o
);
    import mbd_pkg::*;

    logic [NUM_BANKS-1:0][CMP_W-1:0] lower_q;
    logic [NUM_BANKS-1:0][CMP_W-1:0] upper_q;
    logic [NUM_BANKS-1:0]            en_q;
    logic [NUM_BANKS-1:0]            match;
    logic [NUM_BANKS-1:0]            sel;
    logic [BANK_W-1:0]               idx;
    logic                            any_hit;
    logic [CMP_W-1:0]                blk;
    logic                            unused_low;

    // R10: only the granule bits take part in the compare.
    assign blk        = acc_addr_i[ADDR_W-1:GRAN_LSB];
    assign unused_low = ^acc_addr_i[GRAN_LSB-1:0];

    mbd_regs #(.NUM_BANKS(NUM_BANKS), .CMP_W(CMP_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .kind_i  (cfg_kind_e'(cfg_kind_i)),
        .bank_i  (cfg_bank_i),
        .wdata_i (cfg_wdata_i),
        .lower_o (lower_q),
        .upper_o (upper_q),
        .en_o    (en_q)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
        mbd_window #(.CMP_W(CMP_W)) u_win (
            .blk_i   (blk),
            .lower_i (lower_q[b]),
            .upper_i (upper_q[b]),
            .en_i    (en_q[b]),
            .match_o (match[b])
        );
    end

    mbd_prio #(.NUM_BANKS(NUM_BANKS)) u_prio (
        .match_i (match),
        .sel_o   (sel),
        .idx_o   (idx),
        .any_o   (any_hit)
    );

    // Register the decode result; idle outputs when no access was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            cs_o        <= '0;
            bank_idx_o  <= '0;
            hit_o       <= 1'b0;
            miss_o      <= 1'b0;
        end else begin
            out_valid_o <= acc_valid_i;
            cs_o        <= acc_valid_i ? sel : '0;
            bank_idx_o  <= acc_valid_i ? idx : '0;
            hit_o       <= acc_valid_i && any_hit;
            miss_o      <= acc_valid_i && !any_hit;
        end
    end

    // R4: never more than one select at a time.
    assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    // R5: a miss drives no select and no hit.
    assert_miss_no_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (cs_o == '0 && !hit_o));

    // R6: the reported index points at the asserted select.
    assert_index_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> cs_o[bank_idx_o]);

    // R3: a select appears only for a bank enabled when it was decoded.
    assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_o & ~$past(en_q)) == '0));

    // R7: a result follows exactly the cycles with a sampled access.
    assert_result_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid_i) |-> (out_valid_o && (hit_o != miss_o)));

    // R7: with no access, the outputs stay idle.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (cs_o == '0 && !hit_o && !miss_o));
endmodule

// File: tb/tb_mem_bank_decoder.sv
module tb_mem_bank_decoder;
    localparam int NB    = 8;
    localparam int AW    = 32;
    localparam int GL    = 20;
    localparam int CW    = AW - GL;
    localparam int BW    = 3;
    localparam int NBLK  = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [BW-1:0] cfg_bank = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          out_valid;
    logic [NB-1:0] cs;
    logic [BW-1:0] bank_idx;
    logic          hit;
    logic          miss;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_lo [NB];
    int m_hi [NB];
    bit m_en [NB];

    always #2 clk = ~clk;

    mem_bank_decoder #(.NUM_BANKS(NB), .ADDR_W(AW), .GRAN_LSB(GL)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind),
        .cfg_bank_i(cfg_bank), .cfg_wdata_i(cfg_wdata), .acc_valid_i(acc_valid),
        .acc_addr_i(acc_addr), .out_valid_o(out_valid), .cs_o(cs),
        .bank_idx_o(bank_idx), .hit_o(hit), .miss_o(miss)
    );

    task automatic check(bit ok, string tag, string act, string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Register write; the model follows the R8 encoding.
    task automatic cfg_write(int kind, int bank, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind[1:0]; cfg_bank = bank[BW-1:0]; cfg_wdata = data[CW-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
        case (kind)
            0: m_lo[bank] = data;
            1: m_hi[bank] = data;
            2: for (int i = 0; i < NB; i++) m_en[i] = data[i];
            default: ;
        endcase
    endtask

    task automatic set_bank(int b, int lo, int hi);
        cfg_write(0, b, lo);
        cfg_write(1, b, hi);
    endtask

    // One access, its result one clock later, then the idle cycle.
    task automatic access(int blk, int low, string tag);
        int ei;
        bit eh;
        logic [NB-1:0] ecs;
        ei = 0; eh = 0; ecs = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (m_en[i] && blk >= m_lo[i] && blk <= m_hi[i]) begin
                ei = i; eh = 1;
            end
        end
        if (eh) ecs = NB'(1) << ei;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr = {blk[CW-1:0], low[GL-1:0]};
        @(negedge clk);
        acc_valid = 1'b0;
        check(out_valid && cs == ecs && hit == eh && miss == !eh && (!eh || bank_idx == ei[BW-1:0]),
              tag,
              $sformatf("blk=%0d v=%0b cs=%b idx=%0d hit=%0b miss=%0b", blk, out_valid, cs, bank_idx, hit, miss),
              $sformatf("blk=%0d v=1 cs=%b idx=%0d hit=%0b miss=%0b", blk, ecs, ei, eh, !eh));
        @(negedge clk);
        check(!out_valid && cs == '0 && !hit && !miss, "R7 idle",
              $sformatf("v=%0b cs=%b hit=%0b miss=%0b", out_valid, cs, hit, miss),
              "v=0 cs=0 hit=0 miss=0");
    endtask

    // Low bits vary per block to exercise R10.
    task automatic sweep(string tag);
        for (int b = 0; b < NBLK; b++) begin
            int low;
            low = (b % 3 == 0) ? 32'hFFFFF : ((b * 7919 + 13) & 32'hFFFFF);
            access(b, low, tag);
        end
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_en[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && cs == '0 && !hit && !miss, "R1 reset outputs",
              $sformatf("v=%0b cs=%b", out_valid, cs), "v=0 cs=0");
        // R1: all banks disabled, block 0 matches zero bounds but must miss.
        access(0, 0, "R1 reset miss");
        access(NBLK - 1, 5, "R1 reset miss");
        // Overlaps, single-granule, inverted and disabled windows.
        set_bank(0, 0, 99);
        set_bank(1, 100, 100);
        set_bank(2, 50, 300);
        set_bank(3, 2000, NBLK - 1);
        set_bank(4, 600, 500);
        set_bank(5, 3000, 3100);
        set_bank(6, 700, 900);
        set_bank(7, 700, 800);
        cfg_write(2, 6, 8'hDF);
        access(100, 0, "R2 inclusive single granule");
        access(75, 1, "R4 lowest wins");
        access(550, 2, "R9 inverted window");
        access(3050, 3, "R3 disabled bank");
        access(750, 4, "R4 overlap");
        access(301, 0, "R5 gap miss");
        sweep("R2 R4 R5 R6 R9 R10 sweep");
        // R8: code 3 must change nothing.
        cfg_write(3, 0, 12'hABC);
        cfg_write(3, 5, 12'h000);
        access(50, 0, "R8 code3 ignored");
        access(99, 0, "R8 code3 ignored");
        // R8: enable mask ignores the bank field; only bank 5 enabled.
        cfg_write(2, 3, 8'h20);
        sweep("R3 R8 enable mask sweep");
        // Move bank 0 to the top granule, enable it alone.
        set_bank(0, NBLK - 1, NBLK - 1);
        cfg_write(2, 0, 8'h01);
        sweep("R2 R6 top granule sweep");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule